// File: doc/BRIEF.md
# I2C Target Address Decoder

This block sits behind the bit-level receiver of an I2C target port. The receiver hands it one event at a time: a received byte, a START or a STOP. The block follows each frame's address phase and compares it against two programmable target addresses. Each address has its own enable and its own 7-bit or 10-bit mode. The block can also accept the general call address, with separate permission for the on-chip master and for external masters. For every byte it reports the ACK or NACK the receiver should drive. It raises a one-cycle pulse when address 1 is asked for a read. Data bytes written to an accepted address go into a small receive FIFO, each tagged with framing flags.

The event input has no ready signal, because a bus receiver cannot stall. An event is taken in every cycle where `ev_valid` is high. The FIFO output follows valid/ready rules. `rx_valid` stays high, with `rx_data` and `rx_flags` unchanged, until a cycle in which `rx_ready` is also high. That cycle pops the entry. A pop frees a slot only after the clock edge, so a full FIFO stays full for an event that arrives in the same cycle as a pop. A START or STOP that arrives while the block is addressed takes a FIFO entry of its own. Software removes that entry with an ordinary pop.

Top module: `i2c_tgt_decoder`

## Requirements
- R1: After reset the block is outside any frame. `ack_valid`, `rd_evt` and `rx_valid` are low. Bytes arriving before the first START give no ACK report and push nothing.
- R2: A 7-bit match occurs when an address byte that is not 0x00 and does not start with 11110 has bits 7:1 equal to bits 6:0 of an address. That address must be enabled (`cfg_dec` bit 2 for address 1, bit 4 for address 2) and set to 7-bit mode (`cfg_dec` bit 3 or bit 5 low). The match is ACKed. Address 1 wins when both match. Every byte in an open frame gives `ack_valid` high in the next cycle, with the decision on `ack_bit`.
- R3: A 10-bit write match needs two bytes. The first is 11110, then address bits 9:8, then 0. The second equals address bits 7:0. The address must be enabled with its 10-bit bit set. Both bytes are ACKed. Either byte failing to match gives a NACK.
- R4: Address byte 0x00 is a general call. It is ACKed when `cfg_dec` bit 0 is set and `ev_local` is high, or when `cfg_dec` bit 1 is set and `ev_local` is low. Otherwise it is NACKed.
- R5: When the address phase does not match, the byte is NACKed. All further bytes up to the next START are NACKed and push nothing.
- R6: Each data byte of an accepted write is pushed with the byte in `rx_data`. In `rx_flags`, bit 0 marks address 1 and bit 1 marks address 2; general call data has both bits clear. Bit 2 records the ACK sent. That ACK is `cfg_ack` bit 0 for address 1, bit 1 for address 2 and bit 2 for general call.
- R7: The first data byte after an accepted write address carries `rx_flags` bit 4. Later bytes do not.
- R8: A START inside an open frame counts as a repeated START. A repeated START or a STOP that arrives while the block is addressed (write or read) pushes an entry with data 0x00 and `rx_flags` bit 5 (repeated START) or bit 6 (STOP). A START or STOP that arrives while the block is not addressed pushes nothing.
- R9: A read request to address 1 pulses one bit of `rd_evt` in the cycle after the byte. Bit 0 is a 7-bit read after a first START. Bit 1 is a 7-bit read after a repeated START. Bit 2 is a 10-bit read: a header alone with R/W set, after a repeated START, following a 10-bit write match to address 1 in the same frame.
- R10: A data byte that arrives while the FIFO holds `FIFO_DEPTH` entries is NACKed and dropped. The next entry pushed carries `rx_flags` bit 3. A framing entry that meets a full FIFO is dropped.
- R11: `rx_valid` with `rx_ready` low keeps `rx_valid`, `rx_data` and `rx_flags` unchanged in the next cycle. Entries leave in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dec | input | 6 | Address decode control (general call local/external, enable and 10-bit mode per address) |
| cfg_ack | input | 3 | Data ACK enables: address 1, address 2, general call |
| cfg_addr1 | input | 10 | Target address 1 |
| cfg_addr2 | input | 10 | Target address 2 |
| ev_valid | input | 1 | Bus event present this cycle |
| ev_kind | input | 2 | 0 byte, 1 START, 2 STOP |
| ev_byte | input | 8 | Received byte for a byte event |
| ev_local | input | 1 | Frame is driven by the on-chip master |
| ack_valid | output | 1 | ACK decision for the previous cycle's byte |
| ack_bit | output | 1 | 1 = ACK, 0 = NACK |
| rd_evt | output | 3 | Read request pulses for address 1 |
| rx_valid | output | 1 | FIFO entry available |
| rx_ready | input | 1 | Consumer accepts the entry |
| rx_data | output | 8 | Entry data byte |
| rx_flags | output | 7 | Entry tags |

## Verification
The hardest case to reach is the header-only 10-bit read. It requires a complete 10-bit write match, then data, then a repeated START that itself takes a FIFO entry, then a header with R/W set, all inside one frame. The stimulus builds that exact sequence and also repeats the header after a STOP, where the read must be refused. The second hard case is overflow. It holds `rx_ready` low through a burst longer than the FIFO, so that both a data byte and the STOP meet a full FIFO. It then drains the FIFO and starts a fresh write, so that the carried overrun tag shows up on a later entry.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W   = 10;
  localparam int NUM_SLOT = 2;
  localparam int FLAG_W   = 7;

  localparam int FL_DV1   = 0;
  localparam int FL_DV2   = 1;
  localparam int FL_ACKED = 2;
  localparam int FL_OVR   = 3;
  localparam int FL_FIRST = 4;
  localparam int FL_RST   = 5;
  localparam int FL_STOP  = 6;

  typedef enum logic [1:0] {EV_BYTE = 2'd0, EV_START = 2'd1, EV_STOP = 2'd2} ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR2, ST_WRITE, ST_READ, ST_IGNORE
  } dec_state_e;

  typedef enum logic [1:0] {TG_A1 = 2'd0, TG_A2 = 2'd1, TG_GC = 2'd2} target_e;
endpackage

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match #(
  parameter int AW = 10
) (
  input  logic          en,
  input  logic          ten,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    rx_byte,
  output logic          hit7,
  output logic          hdr,
  output logic          lo
);
  localparam logic [4:0] HDR_PAT = 5'b11110;

  assign hit7 = en && !ten && (rx_byte[7:1] == addr[6:0]);
  assign hdr  = en && ten && (rx_byte[7:3] == HDR_PAT) && (rx_byte[2:1] == addr[9:8]);
  assign lo   = (rx_byte == addr[7:0]);
endmodule

// File: rtl/i2c_tgt_fifo.sv
module i2c_tgt_fifo #(
  parameter int DW    = 15,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign full     = (cnt == CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign push     = wr_en && !full;
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rp];

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt_ptr(wp);
      if (pop)  rp <= nxt_ptr(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_ready) |=> full);
endmodule

// File: rtl/i2c_tgt_decoder.sv
module i2c_tgt_decoder
  import i2c_tgt_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_dec,
  input  logic [2:0]        cfg_ack,
  input  logic [ADDR_W-1:0] cfg_addr1,
  input  logic [ADDR_W-1:0] cfg_addr2,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [7:0]        ev_byte,
  input  logic              ev_local,
  output logic              ack_valid,
  output logic              ack_bit,
  output logic [2:0]        rd_evt,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [7:0]        rx_data,
  output logic [FLAG_W-1:0] rx_flags
);
  localparam int ENT_W = FLAG_W + 8;

  logic [ADDR_W-1:0] slot_addr [NUM_SLOT];
  logic [NUM_SLOT-1:0] hit7, hdr, lo;

  assign slot_addr[0] = cfg_addr1;
  assign slot_addr[1] = cfg_addr2;

  for (genvar gi = 0; gi < NUM_SLOT; gi++) begin : g_slot
    i2c_tgt_match #(.AW(ADDR_W)) u_match (
      .en      (cfg_dec[2 + 2*gi]),
      .ten     (cfg_dec[3 + 2*gi]),
      .addr    (slot_addr[gi]),
      .rx_byte (ev_byte),
      .hit7    (hit7[gi]),
      .hdr     (hdr[gi]),
      .lo      (lo[gi])
    );
  end

  dec_state_e st_q, st_d;
  target_e    tgt_q, tgt_d;
  logic       rep_q, rep_d, first_q, first_d, ovr_q, ovr_d;
  logic       tenv_q, tenv_d, tent_q, tent_d;
  logic [NUM_SLOT-1:0] cand_q, cand_d;
  logic       ackv_d, ackb_d;
  logic [2:0] rd_d;

  logic             push;
  logic [ENT_W-1:0] push_ent;
  logic [ENT_W-1:0] pop_ent;
  logic             full;
  logic [FLAG_W-1:0] pf;

  ev_kind_e kind;
  logic     is_byte, is_hdr, rw, addressed, gc_ok;
  logic [NUM_SLOT-1:0] sel2;

  assign kind      = ev_kind_e'(ev_kind);
  assign is_byte   = ev_valid && (kind == EV_BYTE);
  assign is_hdr    = (ev_byte[7:3] == 5'b11110);
  assign rw        = ev_byte[0];
  assign addressed = (st_q == ST_WRITE) || (st_q == ST_READ);
  assign gc_ok     = ev_local ? cfg_dec[0] : cfg_dec[1];
  assign sel2      = cand_q & lo;

  always_comb begin
    st_d    = st_q;
    tgt_d   = tgt_q;
    rep_d   = rep_q;
    first_d = first_q;
    ovr_d   = ovr_q;
    tenv_d  = tenv_q;
    tent_d  = tent_q;
    cand_d  = cand_q;
    ackv_d  = 1'b0;
    ackb_d  = 1'b0;
    rd_d    = 3'b000;
    push    = 1'b0;
    pf      = '0;
    pf[FL_OVR] = ovr_q;
    push_ent = '0;

    if (ev_valid) begin
      unique case (kind)
        EV_START: begin
          if (addressed && !full) begin
            push = 1'b1;
            pf[FL_RST] = 1'b1;
          end
          rep_d = (st_q != ST_IDLE);
          st_d  = ST_ADDR;
        end
        EV_STOP: begin
          if (addressed && !full) begin
            push = 1'b1;
            pf[FL_STOP] = 1'b1;
          end
          st_d   = ST_IDLE;
          rep_d  = 1'b0;
          tenv_d = 1'b0;
        end
        EV_BYTE: begin
          ackv_d = (st_q != ST_IDLE);
          unique case (st_q)
            ST_ADDR: begin
              st_d = ST_IGNORE;
              if (ev_byte == 8'h00) begin
                if (gc_ok) begin
                  ackb_d = 1'b1; st_d = ST_WRITE; tgt_d = TG_GC; first_d = 1'b1;
                end
              end else if (is_hdr) begin
                if (!rw && (|hdr)) begin
                  ackb_d = 1'b1; st_d = ST_ADDR2; cand_d = hdr;
                end else if (rw && rep_q && tenv_q && hdr[tent_q]) begin
                  ackb_d = 1'b1; st_d = ST_READ;
                  tgt_d = tent_q ? TG_A2 : TG_A1;
                  rd_d[2] = !tent_q;
                end
              end else if (|hit7) begin
                ackb_d = 1'b1;
                tgt_d  = hit7[0] ? TG_A1 : TG_A2;
                if (rw) begin
                  st_d = ST_READ;
                  rd_d[0] = hit7[0] && !rep_q;
                  rd_d[1] = hit7[0] && rep_q;
                end else begin
                  st_d = ST_WRITE; first_d = 1'b1;
                end
              end
            end
            ST_ADDR2: begin
              if (|sel2) begin
                ackb_d = 1'b1; st_d = ST_WRITE; first_d = 1'b1;
                tgt_d  = sel2[0] ? TG_A1 : TG_A2;
                tenv_d = 1'b1;
                tent_d = !sel2[0];
              end else begin
                st_d = ST_IGNORE;
              end
            end
            ST_WRITE: begin
              first_d = 1'b0;
              if (full) begin
                ovr_d = 1'b1;
              end else begin
                push   = 1'b1;
                ackb_d = cfg_ack[tgt_q];
                pf[FL_DV1]   = (tgt_q == TG_A1);
                pf[FL_DV2]   = (tgt_q == TG_A2);
                pf[FL_ACKED] = cfg_ack[tgt_q];
                pf[FL_FIRST] = first_q;
                push_ent[7:0] = ev_byte;
              end
            end
            default: ackb_d = 1'b0;
          endcase
        end
        default: ;
      endcase
    end

    if (push) ovr_d = 1'b0;
    push_ent[ENT_W-1:8] = pf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tgt_q     <= TG_A1;
      rep_q     <= 1'b0;
      first_q   <= 1'b0;
      ovr_q     <= 1'b0;
      tenv_q    <= 1'b0;
      tent_q    <= 1'b0;
      cand_q    <= '0;
      ack_valid <= 1'b0;
      ack_bit   <= 1'b0;
      rd_evt    <= 3'b000;
    end else begin
      st_q      <= st_d;
      tgt_q     <= tgt_d;
      rep_q     <= rep_d;
      first_q   <= first_d;
      ovr_q     <= ovr_d;
      tenv_q    <= tenv_d;
      tent_q    <= tent_d;
      cand_q    <= cand_d;
      ack_valid <= ackv_d;
      ack_bit   <= ackb_d;
      rd_evt    <= rd_d;
    end
  end

  i2c_tgt_fifo #(.DW(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (push),
    .wr_data  (push_ent),
    .full     (full),
    .rd_valid (rx_valid),
    .rd_ready (rx_ready),
    .rd_data  (pop_ent)
  );

  assign rx_data  = pop_ent[7:0];
  assign rx_flags = pop_ent[ENT_W-1:8];

  assert_ack_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(is_byte));

  assert_ignore_nacks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE && is_byte) |=> (ack_valid && !ack_bit));

  assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_evt));

  assert_stop_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_ent[8 + FL_STOP]) |-> (ev_valid && kind == EV_STOP && addressed));
endmodule

// File: tb/i2c_tgt_decoder_tb.sv
module i2c_tgt_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cfg_dec = '0;
  logic [2:0] cfg_ack = '0;
  logic [9:0] cfg_addr1 = '0, cfg_addr2 = '0;
  logic ev_valid = 1'b0, ev_local = 1'b0, rx_ready = 1'b1;
  logic [1:0] ev_kind = '0;
  logic [7:0] ev_byte = '0;
  logic ack_valid, ack_bit, rx_valid;
  logic [2:0] rd_evt;
  logic [7:0] rx_data;
  logic [6:0] rx_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_decoder #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dec(cfg_dec), .cfg_ack(cfg_ack),
    .cfg_addr1(cfg_addr1), .cfg_addr2(cfg_addr2),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte), .ev_local(ev_local),
    .ack_valid(ack_valid), .ack_bit(ack_bit), .rd_evt(rd_evt),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_flags(rx_flags)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string scen = "R1 reset";

  // Behavioural reference: state as integers, FIFO as a queue.
  // States: 0 idle, 1 address, 2 second 10-bit byte, 3 write, 4 read, 5 ignore
  logic [14:0] q[$];
  int  m_st, m_tgt, m_tent;
  bit  m_rep, m_first, m_ovr, m_tenv;
  bit [1:0] m_cand;
  bit  e_ackv, e_ackb;
  bit [2:0] e_rd;
  bit  do_push, was_full;
  logic [14:0] ent;

  function automatic bit slot_en(int i);
    return cfg_dec[2 + 2*i];
  endfunction
  function automatic bit slot_ten(int i);
    return cfg_dec[3 + 2*i];
  endfunction
  function automatic logic [9:0] slot_addr(int i);
    return (i == 0) ? cfg_addr1 : cfg_addr2;
  endfunction
  function automatic bit m7(int i, logic [7:0] b);
    return slot_en(i) && !slot_ten(i) && (b[7:1] == slot_addr(i)[6:0]);
  endfunction
  function automatic bit mh(int i, logic [7:0] b);
    return slot_en(i) && slot_ten(i) && (b[7:3] == 5'b11110) && (b[2:1] == slot_addr(i)[9:8]);
  endfunction

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", scen, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tgt = 0; m_tent = 0; m_rep = 0; m_first = 0; m_ovr = 0;
      m_tenv = 0; m_cand = 0; e_ackv = 0; e_ackb = 0; e_rd = 0;
      q.delete();
    end else begin
      e_ackv = 0; e_ackb = 0; e_rd = 0; do_push = 0; ent = '0;
      was_full = (q.size() >= DEPTH);
      if (ev_valid) begin
        if (ev_kind == 2'd1) begin
          if ((m_st == 3 || m_st == 4) && !was_full) begin do_push = 1; ent[13] = 1; end
          m_rep = (m_st != 0);
          m_st = 1;
        end else if (ev_kind == 2'd2) begin
          if ((m_st == 3 || m_st == 4) && !was_full) begin do_push = 1; ent[14] = 1; end
          m_st = 0; m_rep = 0; m_tenv = 0;
        end else begin
          e_ackv = (m_st != 0);
          if (m_st == 1) begin
            if (ev_byte == 8'h00) begin
              if (ev_local ? cfg_dec[0] : cfg_dec[1]) begin
                e_ackb = 1; m_st = 3; m_tgt = 2; m_first = 1;
              end else m_st = 5;
            end else if (ev_byte[7:3] == 5'b11110) begin
              if (!ev_byte[0] && (mh(0, ev_byte) || mh(1, ev_byte))) begin
                e_ackb = 1; m_st = 2; m_cand = {mh(1, ev_byte), mh(0, ev_byte)};
              end else if (ev_byte[0] && m_rep && m_tenv && mh(m_tent, ev_byte)) begin
                e_ackb = 1; m_st = 4; m_tgt = m_tent;
                if (m_tent == 0) e_rd[2] = 1;
              end else m_st = 5;
            end else if (m7(0, ev_byte) || m7(1, ev_byte)) begin
              e_ackb = 1;
              m_tgt = m7(0, ev_byte) ? 0 : 1;
              if (ev_byte[0]) begin
                m_st = 4;
                if (m_tgt == 0) e_rd[m_rep ? 1 : 0] = 1;
              end else begin
                m_st = 3; m_first = 1;
              end
            end else m_st = 5;
          end else if (m_st == 2) begin
            if (m_cand[0] && ev_byte == cfg_addr1[7:0]) begin
              e_ackb = 1; m_st = 3; m_first = 1; m_tgt = 0; m_tenv = 1; m_tent = 0;
            end else if (m_cand[1] && ev_byte == cfg_addr2[7:0]) begin
              e_ackb = 1; m_st = 3; m_first = 1; m_tgt = 1; m_tenv = 1; m_tent = 1;
            end else m_st = 5;
          end else if (m_st == 3) begin
            if (was_full) m_ovr = 1;
            else begin
              do_push = 1;
              e_ackb = cfg_ack[m_tgt];
              ent[7:0] = ev_byte;
              ent[8] = (m_tgt == 0);
              ent[9] = (m_tgt == 1);
              ent[10] = cfg_ack[m_tgt];
              ent[12] = m_first;
            end
            m_first = 0;
          end
        end
      end
      if (do_push) begin
        ent[11] = m_ovr;
        m_ovr = 0;
      end
      if (q.size() > 0 && rx_ready) void'(q.pop_front());
      if (do_push) q.push_back(ent);
    end
    #2;
    chk("ack_valid", ack_valid, e_ackv);
    if (e_ackv) chk("ack_bit", ack_bit, e_ackb);
    chk("rd_evt", rd_evt, e_rd);
    chk("rx_valid", rx_valid, q.size() > 0);
    if (q.size() > 0) begin
      chk("rx_data", rx_data, q[0][7:0]);
      chk("rx_flags", rx_flags, q[0][14:8]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog %s: actual %0d cycles expected completion", scen, cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic ev(input logic [1:0] k, input logic [7:0] b, input logic loc = 1'b0);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b; ev_local = loc;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask
  task automatic sta(); ev(2'd1, 8'h00); endtask
  task automatic sto(); ev(2'd2, 8'h00); endtask
  task automatic wb(input logic [7:0] b, input logic loc = 1'b0); ev(2'd0, b, loc); endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  initial begin
    idle(3);
    // R1: outputs quiet in reset and just after
    chk("R1 ack_valid in reset", ack_valid, 0);
    chk("R1 rx_valid in reset", rx_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1 rd_evt after reset", rd_evt, 0);
    wb(8'h54);  // byte outside any frame: no ack report, no push

    cfg_addr1 = 10'h02A; cfg_addr2 = 10'h2B5;
    cfg_dec = 6'b110110; cfg_ack = 3'b111;

    // R2 R6 R7 R8: 7-bit write to address 1 with STOP entry
    scen = "R2/R6/R7/R8 7-bit write";
    sta(); wb(8'h54); wb(8'h11); wb(8'h22); sto(); idle(3);

    // R3 R8: 10-bit write to address 2, repeated START entry, header read (address 2: no pulse)
    scen = "R3/R8 10-bit write";
    sta(); wb(8'hF4); wb(8'hB5); wb(8'h33); sta(); wb(8'hF5); sto(); idle(3);
    scen = "R3 10-bit low byte mismatch";
    sta(); wb(8'hF4); wb(8'hB4); wb(8'h44); sto(); idle(3);

    // R4: general call external accepted, local refused
    scen = "R4 general call";
    sta(); wb(8'h00, 1'b0); wb(8'h5A, 1'b0); sto();
    sta(); wb(8'h00, 1'b1); wb(8'h5B, 1'b1); sto(); idle(3);

    // R5: no match, ignored until START, then matched after repeated START
    scen = "R5 no match";
    sta(); wb(8'h20); wb(8'h54); wb(8'h66); sto();
    sta(); wb(8'hF6); wb(8'h77); sta(); wb(8'h54); wb(8'h88); sto(); idle(3);

    // R9: read requests to address 1
    scen = "R9 read pulses";
    sta(); wb(8'h55); sta(); wb(8'h55); sto(); idle(3);

    // R2: both 7-bit with same address, address 1 wins
    scen = "R2 priority";
    cfg_addr2 = 10'h02A; cfg_dec = 6'b010100;
    sta(); wb(8'h54); wb(8'h99); sto(); idle(3);

    // R6: ACK disable for address 1 data
    scen = "R6 ack disabled";
    cfg_ack = 3'b110;
    sta(); wb(8'h54); wb(8'hA1); sto(); idle(3);
    cfg_ack = 3'b111;

    // R9: 10-bit header-only read on address 1; refused after STOP
    scen = "R9 10-bit read";
    cfg_addr1 = 10'h1C3; cfg_dec = 6'b001100;
    sta(); wb(8'hF2); wb(8'hC3); wb(8'h12); sta(); wb(8'hF3); sto();
    sta(); wb(8'hF3); sto(); idle(3);

    // R10 R11: overflow with consumer stalled, then drain and new write
    scen = "R10/R11 overflow";
    cfg_addr1 = 10'h02A; cfg_dec = 6'b000100;
    rx_ready = 1'b0;
    sta(); wb(8'h54);
    for (int i = 0; i < 10; i++) wb(8'(8'hC0 + i));
    sto(); idle(4);
    rx_ready = 1'b1; idle(12);
    sta(); wb(8'h54); wb(8'h77); sto(); idle(4);

    // R11: toggling ready during a write
    scen = "R11 ready toggling";
    sta(); wb(8'h54);
    for (int i = 0; i < 6; i++) begin
      rx_ready = i[0];
      wb(8'(8'h30 + i));
    end
    sto();
    rx_ready = 1'b1; idle(12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule